// File: doc/BRIEF.md
# Atomic Memory Read-Modify-Write Engine

This block performs one atomic operation at a time on a single-port synchronous memory that holds 64-bit words. A requester presents the operand width, an 8-bit operation code, a base address with a signed 16-bit displacement, a source value and the current value of the accumulator register. The engine then owns the memory for the whole sequence: it reads the addressed word, computes the new value, writes it back when required, and reports the value that was in memory before the change.

The supported operations are add, or, and, exclusive-or, swap and compare-and-swap. The first four can optionally fetch the old value. Swap and compare-and-swap always fetch. A `lock` output stays high from the read through the write, so that other memory clients can be held off. At completion the engine raises `done` for one cycle. Two flags then say whether the requester must load `old_val` into its source register (`wb_src`) or into its accumulator (`wb_r0`). Malformed requests end at once with `err` and touch no memory.

Top module: `amo_engine`

## Requirements
- R1: A request is taken only when `req_valid` is high and `busy` is low. `req_valid` is ignored while an operation is in flight.
- R2: The width code `req_size` is 2'b10 for 32 bits and 2'b11 for 64 bits. Codes 2'b00 (byte) and 2'b01 (half word) are rejected. A rejected request gives `done` and `err` one cycle after acceptance, with no memory access, `old_val` zero, and both writeback flags low.
- R3: The effective address is `req_base` plus the sign-extended `req_off`, wrapped to ADDR_W bits. A 64-bit request needs address bits [2:0] zero. A 32-bit request needs address bits [1:0] zero. A misaligned request is rejected as in R2.
- R4: Accepted operation codes are 0x00 add, 0x40 or, 0x50 and and 0xa0 xor, each also with bit 0 set. Bit 0 is the fetch flag. 0xe1 is swap and 0xf1 is compare-and-swap. Any other code, including 0xe0 and 0xf0, is rejected as in R2.
- R5: Add, or, and and xor store `mem op src` at the addressed operand. A 32-bit add wraps modulo 2^32.
- R6: Add, or, and and xor return the old operand on `old_val`. `wb_src` is high at `done` exactly when the fetch bit is set.
- R7: Swap stores the source value, returns the old operand and raises `wb_src`.
- R8: Compare-and-swap with old operand equal to `req_r0` (low 32 bits for a 32-bit request) stores the source value. It raises `wb_r0` with the zero-extended old operand and never raises `wb_src`.
- R9: Compare-and-swap with no match performs no write. It still holds `lock`, returns the old operand with `wb_r0`, and finishes one cycle earlier.
- R10: A 32-bit operation acts on the low half of the 64-bit word when address bit 2 is 0, and on the high half when it is 1. The other half is written back unchanged. The fetched value is zero-extended.
- R11: `lock` is high in exactly the read, wait, modify and write cycles: 4 cycles for a writing operation, 3 for a compare miss and 0 for a rejection. Memory is enabled only while `lock` is high. An operation uses one read and at most one write.
- R12: `done` is a one-cycle pulse. It arrives 5 cycles after acceptance for a writing operation, 4 cycles after for a compare miss, and 1 cycle after for a rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_size | input | 2 | Operand width code (2'b10 = 32, 2'b11 = 64) |
| req_op | input | 8 | Operation code with fetch flag in bit 0 |
| req_base | input | ADDR_W | Base byte address |
| req_off | input | OFF_W | Signed byte displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Accumulator value used as compare operand |
| busy | output | 1 | Operation in flight |
| lock | output | 1 | Memory held for the atomic sequence |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W-3 | Memory word index |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid one cycle after a read strobe |
| done | output | 1 | Completion pulse |
| err | output | 1 | Rejected request, valid with done |
| old_val | output | 64 | Zero-extended pre-modification operand, valid with done |
| wb_src | output | 1 | Load old_val into the source register |
| wb_r0 | output | 1 | Load old_val into the accumulator |

## Verification
The bench drives each request at a falling edge and counts falling edges until `done`. It expects `done` on the 5th for a writing operation, the 4th for a compare miss and the 1st for a rejection. All result checks (memory word, `old_val`, writeback flags) are made at that same falling edge. The write lands on the rising edge that enters the done cycle, so the bench's memory model is already updated when it is read. Lock cycles and memory strobes are counted on the rising edges between acceptance and `done`, and compared with the totals R11 gives for each outcome.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;

  localparam logic [1:0] SZ_W32 = 2'b10;
  localparam logic [1:0] SZ_W64 = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_MODIFY, ST_WRITE, ST_DONE
  } amo_state_e;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_SWAP, K_CAS
  } amo_kind_e;

  typedef struct packed {
    logic      known;
    amo_kind_e kind;
    logic      fetch;
  } amo_code_t;

  typedef struct packed {
    amo_kind_e kind;
    logic      fetch;
    logic      wide;
    logic      hi;
  } amo_dec_t;

  // Operation code table: the fetch flag is bit 0; swap and cas need it.
  function automatic amo_code_t decode_code(input logic [7:0] code);
    amo_code_t r;
    r.known = 1'b1;
    r.fetch = code[0];
    r.kind  = K_ADD;
    case (code)
      8'h00, 8'h01: r.kind = K_ADD;
      8'h40, 8'h41: r.kind = K_OR;
      8'h50, 8'h51: r.kind = K_AND;
      8'ha0, 8'ha1: r.kind = K_XOR;
      8'he1:        r.kind = K_SWAP;
      8'hf1:        r.kind = K_CAS;
      default:      r.known = 1'b0;
    endcase
    return r;
  endfunction

  // Zero-extended operand selected from a memory word.
  function automatic logic [XLEN-1:0] lane_pick(input logic [XLEN-1:0] w,
                                                input logic wide,
                                                input logic hi);
    if (wide) return w;
    if (hi)   return {{HALF{1'b0}}, w[XLEN-1:HALF]};
    return {{HALF{1'b0}}, w[HALF-1:0]};
  endfunction

  // New operand value; a cas miss returns the memory value unchanged.
  function automatic logic [XLEN-1:0] op_apply(input amo_kind_e k,
                                               input logic [XLEN-1:0] m,
                                               input logic [XLEN-1:0] s,
                                               input logic [XLEN-1:0] c);
    case (k)
      K_ADD:   return m + s;
      K_OR:    return m | s;
      K_AND:   return m & s;
      K_XOR:   return m ^ s;
      K_SWAP:  return s;
      K_CAS:   return (m == c) ? s : m;
      default: return m;
    endcase
  endfunction

  // Put an operand back into its word, leaving the other half intact.
  function automatic logic [XLEN-1:0] lane_merge(input logic [XLEN-1:0] w,
                                                 input logic [XLEN-1:0] v,
                                                 input logic wide,
                                                 input logic hi);
    if (wide) return v;
    if (hi)   return {v[HALF-1:0], w[HALF-1:0]};
    return {w[XLEN-1:HALF], v[HALF-1:0]};
  endfunction
endpackage

// File: rtl/amo_req_check.sv
module amo_req_check
  import amo_pkg::*;
(
  input  logic [1:0] size,
  input  logic [7:0] code,
  input  logic [2:0] addr_lo,
  output logic       bad,
  output amo_dec_t   dec
);
  amo_code_t cd;
  logic      size_ok;
  logic      wide;
  logic      aligned;

  always_comb begin
    cd      = decode_code(code);
    wide    = (size == SZ_W64);
    size_ok = (size == SZ_W64) || (size == SZ_W32);
    aligned = wide ? (addr_lo == 3'b000) : (addr_lo[1:0] == 2'b00);
    bad     = !size_ok || !cd.known || !aligned;
    dec.kind  = cd.kind;
    dec.fetch = cd.fetch;
    dec.wide  = wide;
    dec.hi    = !wide && addr_lo[2];
  end
endmodule

// File: rtl/amo_lane_alu.sv
module amo_lane_alu
  import amo_pkg::*;
(
  input  amo_dec_t          dec,
  input  logic [XLEN-1:0]   old_word,
  input  logic [XLEN-1:0]   src,
  input  logic [XLEN-1:0]   r0,
  output logic [XLEN-1:0]   fetched,
  output logic [XLEN-1:0]   new_word,
  output logic              cas_hit
);
  logic [XLEN-1:0] src_op;
  logic [XLEN-1:0] cmp_op;
  logic [XLEN-1:0] result;

  always_comb begin
    fetched  = lane_pick(old_word, dec.wide, dec.hi);
    src_op   = lane_pick(src, dec.wide, 1'b0);
    cmp_op   = lane_pick(r0, dec.wide, 1'b0);
    cas_hit  = (fetched == cmp_op);
    result   = op_apply(dec.kind, fetched, src_op, cmp_op);
    new_word = lane_merge(old_word, result, dec.wide, dec.hi);
  end
endmodule

// File: rtl/amo_seq.sv
module amo_seq
  import amo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       reject,
  input  logic       cas_op,
  input  logic       cas_hit,
  output amo_state_e state
);
  amo_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (start) nxt = reject ? ST_DONE : ST_READ;
      ST_READ:   nxt = ST_WAIT;
      ST_WAIT:   nxt = ST_MODIFY;
      ST_MODIFY: nxt = (cas_op && !cas_hit) ? ST_DONE : ST_WRITE;
      ST_WRITE:  nxt = ST_DONE;
      ST_DONE:   nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/amo_engine.sv
module amo_engine
  import amo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_r0,
  output logic              busy,
  output logic              lock,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-4:0] mem_addr,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              done,
  output logic              err,
  output logic [63:0]       old_val,
  output logic              wb_src,
  output logic              wb_r0
);
  localparam int IDX_W = ADDR_W - 3;

  amo_state_e        state;
  logic [ADDR_W-1:0] eff_addr;
  logic              bad;
  amo_dec_t          dec_in;
  amo_dec_t          dec_q;
  logic [IDX_W-1:0]  widx_q;
  logic [XLEN-1:0]   src_q;
  logic [XLEN-1:0]   r0_q;
  logic [XLEN-1:0]   old_q;
  logic              err_q;
  logic [XLEN-1:0]   fetched;
  logic [XLEN-1:0]   new_word;
  logic              cas_hit;
  logic              is_cas;
  logic              show;

  // Named internal events for the checker
  logic ev_accept;
  logic ev_reject;
  logic ev_cas_miss;
  logic ev_write;

  assign eff_addr = req_base + ADDR_W'($signed(req_off));

  amo_req_check u_check (
    .size    (req_size),
    .code    (req_op),
    .addr_lo (eff_addr[2:0]),
    .bad     (bad),
    .dec     (dec_in)
  );

  amo_lane_alu u_alu (
    .dec      (dec_q),
    .old_word (old_q),
    .src      (src_q),
    .r0       (r0_q),
    .fetched  (fetched),
    .new_word (new_word),
    .cas_hit  (cas_hit)
  );

  assign is_cas = (dec_q.kind == K_CAS);

  amo_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (req_valid),
    .reject  (bad),
    .cas_op  (is_cas),
    .cas_hit (cas_hit),
    .state   (state)
  );

  assign busy        = (state != ST_IDLE);
  assign ev_accept   = req_valid && (state == ST_IDLE);
  assign ev_reject   = ev_accept && bad;
  assign ev_cas_miss = (state == ST_MODIFY) && is_cas && !cas_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '{kind: K_ADD, fetch: 1'b0, wide: 1'b0, hi: 1'b0};
      widx_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      err_q  <= 1'b0;
      old_q  <= '0;
    end else begin
      if (ev_accept) begin
        dec_q  <= dec_in;
        widx_q <= eff_addr[ADDR_W-1:3];
        src_q  <= req_src;
        r0_q   <= req_r0;
        err_q  <= bad;
      end
      if (state == ST_WAIT) old_q <= mem_rdata;
    end
  end

  assign lock      = (state == ST_READ) || (state == ST_WAIT) ||
                     (state == ST_MODIFY) || (state == ST_WRITE);
  assign mem_en    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign ev_write  = mem_we;
  assign mem_addr  = widx_q;
  assign mem_wdata = new_word;

  assign done    = (state == ST_DONE);
  assign err     = done && err_q;
  assign show    = done && !err_q;
  assign old_val = show ? fetched : '0;
  assign wb_src  = show && dec_q.fetch && !is_cas;
  assign wb_r0   = show && is_cas;
endmodule

// File: rtl/amo_engine_chk.sv
module amo_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic lock,
  input logic mem_en,
  input logic done,
  input logic err,
  input logic wb_src,
  input logic wb_r0,
  input logic ev_accept,
  input logic ev_reject,
  input logic ev_cas_miss,
  input logic ev_write
);
  // R11
  mem_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> lock);

  // R11
  done_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lock);

  // R11
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> busy);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  // R2
  reject_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (done && err));

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_en && !wb_src && !wb_r0));

  // R8
  wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_src, wb_r0}));

  // R9
  cas_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cas_miss |=> (done && !mem_en));

  // R12
  write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |=> done);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind amo_engine amo_engine_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .lock        (lock),
  .mem_en      (mem_en),
  .done        (done),
  .err         (err),
  .wb_src      (wb_src),
  .wb_r0       (wb_r0),
  .ev_accept   (ev_accept),
  .ev_reject   (ev_reject),
  .ev_cas_miss (ev_cas_miss),
  .ev_write    (ev_write)
);

// File: tb/amo_engine_tb.sv
`timescale 1ns/1ps
module amo_engine_tb;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 3);

  typedef struct packed {
    logic [1:0]  sz;
    logic [7:0]  op;
    logic [7:0]  base;
    logic [15:0] off;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] mw;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 8'h00, 8'h10, 16'h0000, 64'h0000_0001_0000_0005, 64'h0, 64'h0000_0000_FFFF_FFFF}, // R5
    '{2'b11, 8'h01, 8'h18, 16'h0000, 64'h1, 64'h0, 64'h0000_0000_FFFF_FFFF},                  // R6
    '{2'b10, 8'h00, 8'h20, 16'h0000, 64'hDEAD_0000_0000_0002, 64'h0, 64'h1234_5678_FFFF_FFFF}, // R10 wrap
    '{2'b10, 8'h41, 8'h28, 16'h0004, 64'h0000_0000_0F0F_0000, 64'h0, 64'hA000_0001_5555_5555}, // R10 high
    '{2'b11, 8'h51, 8'h30, 16'h0000, 64'hFF00_FF00_FF00_FF00, 64'h0, 64'h1234_5678_9ABC_DEF0}, // R6
    '{2'b10, 8'ha0, 8'h38, 16'h0004, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0123_4567_89AB_CDEF}, // R5
    '{2'b11, 8'he1, 8'h40, 16'h0000, 64'hCAFE_F00D_0BAD_BEEF, 64'h0, 64'h1111_2222_3333_4444}, // R7
    '{2'b10, 8'he1, 8'h48, 16'h0000, 64'h9999_9999_7777_7777, 64'h0, 64'hAAAA_BBBB_CCCC_DDDD}, // R7
    '{2'b11, 8'hf1, 8'h50, 16'h0000, 64'h5, 64'h1111_2222_3333_4444, 64'h1111_2222_3333_4444}, // R8
    '{2'b11, 8'hf1, 8'h58, 16'h0000, 64'h5, 64'h1111_2222_3333_4445, 64'h1111_2222_3333_4444}, // R9
    '{2'b10, 8'hf1, 8'h60, 16'h0004, 64'hAB, 64'hFFFF_FFFF_8000_0000, 64'h8000_0000_0000_0007}, // R8
    '{2'b10, 8'hf1, 8'h68, 16'h0000, 64'h1, 64'h9, 64'h0000_0009_0000_0008},                    // R9
    '{2'b00, 8'h00, 8'h70, 16'h0000, 64'h1, 64'h0, 64'h0000_0000_0000_0070},                    // R2
    '{2'b01, 8'h01, 8'h78, 16'h0000, 64'h1, 64'h0, 64'h0000_0000_0000_0078},                    // R2
    '{2'b11, 8'h00, 8'h80, 16'h0004, 64'h1, 64'h0, 64'h0000_0000_0000_0080},                    // R3
    '{2'b10, 8'h00, 8'h88, 16'h0002, 64'h1, 64'h0, 64'h0000_0000_0000_0088},                    // R3
    '{2'b11, 8'h10, 8'h90, 16'h0000, 64'h1, 64'h0, 64'h0000_0000_0000_0090},                    // R4
    '{2'b11, 8'he0, 8'h98, 16'h0000, 64'h1, 64'h0, 64'h0000_0000_0000_0098},                    // R4
    '{2'b11, 8'ha1, 8'hB0, 16'hFFF8, 64'h00FF_00FF_00FF_00FF, 64'h0, 64'h0F0F_0F0F_0F0F_0F0F}, // R3 neg offset
    '{2'b10, 8'h50, 8'hC0, 16'h0000, 64'h0000_0000_00FF_F0F0, 64'h0, 64'h7777_7777_1234_5678}  // R5
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_size = '0;
  logic [7:0]    req_op = '0;
  logic [AW-1:0] req_base = '0;
  logic [15:0]   req_off = '0;
  logic [63:0]   req_src = '0;
  logic [63:0]   req_r0 = '0;
  logic          busy, lock, mem_en, mem_we, done, err, wb_src, wb_r0;
  logic [AW-4:0] mem_addr;
  logic [63:0]   mem_wdata, old_val;
  logic [63:0]   mem_rdata = '0;

  logic [63:0] mem [NW];

  int n_chk = 0;
  int n_fail = 0;
  bit mon = 1'b0;
  int en_cnt, we_cnt, lk_cnt, done_cnt;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  amo_engine #(.ADDR_W(AW), .OFF_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_op(req_op), .req_base(req_base), .req_off(req_off), .req_src(req_src),
    .req_r0(req_r0), .busy(busy), .lock(lock), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .err(err), .old_val(old_val), .wb_src(wb_src), .wb_r0(wb_r0)
  );

  // Single-port synchronous memory, read-first
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (mon) begin
      if (mem_en) en_cnt++;
      if (mem_we) we_cnt++;
      if (lock)   lk_cnt++;
      if (done)   done_cnt++;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act cycles %0d exp < 100000", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act %h exp %h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic ref_model(input vec_t v, output logic e_err,
                           output logic [63:0] e_mem, output logic [63:0] e_old,
                           output logic e_ws, output logic e_wr,
                           output int e_lat, output int e_lk, output int e_en,
                           output int e_we, output string tag);
    logic [7:0]  a;
    logic        w64, hi, known;
    logic [63:0] o, s, r, n;
    a = v.base + v.off[7:0];
    e_mem = v.mw; e_old = '0; e_ws = 1'b0; e_wr = 1'b0; e_err = 1'b0;
    e_lat = 1; e_lk = 0; e_en = 0; e_we = 0;
    w64 = (v.sz == 2'b11);
    known = (v.op inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                          8'ha0, 8'ha1, 8'he1, 8'hf1});
    if (v.sz != 2'b10 && v.sz != 2'b11) begin
      e_err = 1'b1; tag = "R2";
    end else if (!known) begin
      e_err = 1'b1; tag = "R4";
    end else if (w64 ? (a[2:0] != 3'd0) : (a[1:0] != 2'd0)) begin
      e_err = 1'b1; tag = "R3";
    end else begin
      hi = !w64 && a[2];
      if (w64)     o = v.mw;
      else if (hi) o = {32'h0, v.mw[63:32]};
      else         o = {32'h0, v.mw[31:0]};
      s = w64 ? v.src : {32'h0, v.src[31:0]};
      r = w64 ? v.r0  : {32'h0, v.r0[31:0]};
      tag = v.op[0] ? "R6" : "R5";
      case (v.op[7:4])
        4'h0: n = o + s;
        4'h4: n = o | s;
        4'h5: n = o & s;
        4'ha: n = o ^ s;
        4'he: begin n = s; tag = "R7"; end
        default: begin n = (o == r) ? s : o; tag = (o == r) ? "R8" : "R9"; end
      endcase
      if (!w64) tag = {tag, "/R10"};
      if (w64)     e_mem = n;
      else if (hi) e_mem[63:32] = n[31:0];
      else         e_mem[31:0] = n[31:0];
      e_old = o;
      e_wr  = (v.op[7:4] == 4'hf);
      e_ws  = v.op[0] && !e_wr;
      if (e_wr && o != r) begin
        e_lat = 4; e_lk = 3; e_en = 1; e_we = 0;
      end else begin
        e_lat = 5; e_lk = 4; e_en = 2; e_we = 1;
      end
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic        e_err, e_ws, e_wr;
    logic [63:0] e_mem, e_old;
    int          e_lat, e_lk, e_en, e_we, cnt;
    string       tag;
    logic [4:0]  idx;
    logic [7:0]  a;
    ref_model(v, e_err, e_mem, e_old, e_ws, e_wr, e_lat, e_lk, e_en, e_we, tag);
    a   = v.base + v.off[7:0];
    idx = a[7:3];
    @(negedge clk);
    mem[idx]  = v.mw;
    req_valid = 1'b1; req_size = v.sz; req_op = v.op; req_base = v.base;
    req_off   = v.off; req_src = v.src; req_r0 = v.r0;
    en_cnt = 0; we_cnt = 0; lk_cnt = 0; done_cnt = 0; mon = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) req_valid = 1'b0;
    end while (!done && cnt < 20);
    mon = 1'b0;
    chk({tag, " R12"}, "done latency", 64'(cnt), 64'(e_lat));
    chk(tag, "err", {63'h0, err}, {63'h0, e_err});
    chk(tag, "old_val", old_val, e_old);
    chk(tag, "wb_src", {63'h0, wb_src}, {63'h0, e_ws});
    chk(tag, "wb_r0", {63'h0, wb_r0}, {63'h0, e_wr});
    chk(tag, "memory word", mem[idx], e_mem);
    chk({tag, " R11"}, "lock cycles", 64'(lk_cnt), 64'(e_lk));
    chk({tag, " R11"}, "mem strobes", 64'(en_cnt), 64'(e_en));
    chk({tag, " R11"}, "mem writes", 64'(we_cnt), 64'(e_we));
    @(negedge clk);
    chk({tag, " R12"}, "done pulse width", {63'h0, done}, 64'h0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 64'(i) * 64'h0101_0101_0101_0101;
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1", "busy in reset", {63'h0, busy}, 64'h0);
    chk("R11", "lock in reset", {63'h0, lock}, 64'h0);
    chk("R12", "done in reset", {63'h0, done}, 64'h0);
    chk("R11", "mem_en in reset", {63'h0, mem_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", {63'h0, busy}, 64'h0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R1: a request held during an operation is ignored
    @(negedge clk);
    mem[28] = 64'h5555_0000_0000_000A;
    mem[29] = 64'h0123_0000_0000_0000;
    req_valid = 1'b1; req_size = 2'b10; req_op = 8'h00; req_base = 8'hE0;
    req_off = 16'h0; req_src = 64'h3; req_r0 = 64'h0;
    done_cnt = 0; mon = 1'b1;
    @(negedge clk);
    req_size = 2'b11; req_op = 8'ha0; req_base = 8'hE8; req_src = 64'hFFFF;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    mon = 1'b0;
    chk("R1", "target word", mem[28], 64'h5555_0000_0000_000D);
    chk("R1", "word named while busy", mem[29], 64'h0123_0000_0000_0000);
    chk("R1", "done pulses", 64'(done_cnt), 64'h1);
    chk("R1", "idle after op", {63'h0, busy}, 64'h0);

    summary();
  end
endmodule